// File: doc/BRIEF.md
# Per-Peripheral Clock Enable Bank

This block keeps one clock-enable flag for each peripheral of a chip. Bit n of the bank belongs to the peripheral whose identifier is n. By convention that identifier is also the peripheral's interrupt line number. Each flag drives one gated-clock enable output, and the gating cell itself sits outside this block.

Software reaches the bank through two write-only registers. Ones written to the enable register switch the matching clocks on. Ones written to the disable register switch them off. Zero bits in either write are ignored. The register decoder upstream presents each write as a strobe and a 32-bit data word. The current flags are presented as a status vector, and that vector is also the set of clock-enable outputs.

Every clock is off after reset. A disable takes effect at the next edge. The block does not wait for the peripheral to go idle, so software must confirm that the peripheral has finished before it writes the disable bit. Identifiers that have no peripheral are fixed at zero by a parameter mask.

Top module: `periph_clk_enable`

## Requirements
- R1: While reset is high and on the first cycle after it, every bit of the enable vector is 0.
- R2: A write to the enable register with bit n set turns enable n on, where n is any identifier marked as implemented in the mask. The change appears on the cycle after the write.
- R3: A write to the disable register with bit n set turns enable n off on the cycle after the write, whatever the peripheral is doing at the time.
- R4: Any bit that is 0 in the data of an accepted enable or disable write keeps its previous state.
- R5: If the same bit is set in both an enable write and a disable write presented in the same cycle, the disable wins and the bit ends up 0.
- R6: A bit whose position is 0 in the IMPL_MASK parameter always reads 0 and ignores set writes. The default mask is 32'h0FFF_FFFC, which leaves bits 0, 1 and 28 to 31 unimplemented.
- R7: Data presented while its write strobe is low has no effect.
- R8: The enable vector changes only on the clock edge that accepts a write. It does not change combinationally when the inputs change, and it holds steady on cycles with no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Write strobe of the enable register |
| set_wdata | input | 32 | Ones select the clocks to enable |
| clr_we | input | 1 | Write strobe of the disable register |
| clr_wdata | input | 32 | Ones select the clocks to disable |
| clk_en | output | 32 | Per-identifier clock enables, also read as the status register |

## Verification
The bench walks a single one through all 32 positions of the enable register and of the disable register. This sweep exposes a design with a bit-index swap, one that leaks a write into an unimplemented identifier, or one that fails to set or clear a bit. Each position is also hit by an enable and a disable in the same cycle, so a design that lets the enable win leaves that clock running. Full-width data is driven with the strobes low, and every write is checked against the old value before the edge. A design that ignores a strobe or passes a write through combinationally shows up in these checks. A long pseudo-random run and a reset in the middle of it exercise mixed patterns, and a design that touches the zero bits of a write or misses the reset fails there.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int unsigned PCE_IDS = 32;

    typedef logic [PCE_IDS-1:0] pce_vec_t;

    typedef struct packed {
        pce_vec_t on_bits;
        pce_vec_t off_bits;
    } pce_req_t;

    // Next state of one enable flag: the off request dominates.
    function automatic logic pce_bit_next(input logic cur,
                                          input logic on_req,
                                          input logic off_req);
        logic nxt;
        if (off_req)
            nxt = 1'b0;
        else
            nxt = cur | on_req;
        return nxt;
    endfunction

endpackage

// File: rtl/pce_req_decode.sv
module pce_req_decode
    import pce_pkg::*;
#(
    parameter pce_vec_t IMPL_MASK = 32'h0FFF_FFFC
) (
    input  logic     set_we,
    input  pce_vec_t set_wdata,
    input  logic     clr_we,
    input  pce_vec_t clr_wdata,
    output pce_req_t req
);

    always_comb begin
        req.on_bits  = set_we ? (set_wdata & IMPL_MASK) : '0;
        req.off_bits = clr_we ? (clr_wdata & IMPL_MASK) : '0;
    end

endmodule

// File: rtl/pce_enable_cell.sv
module pce_enable_cell
    import pce_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    output logic en
);

    always_ff @(posedge clk) begin
        if (rst)
            en <= 1'b0;
        else
            en <= pce_bit_next(en, on_req, off_req);
    end

endmodule

// File: rtl/periph_clk_enable.sv
module periph_clk_enable
    import pce_pkg::*;
#(
    parameter pce_vec_t IMPL_MASK = 32'h0FFF_FFFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_we,
    input  logic [31:0] set_wdata,
    input  logic        clr_we,
    input  logic [31:0] clr_wdata,
    output logic [31:0] clk_en
);

    pce_req_t req;
    pce_vec_t en_q;

    pce_req_decode #(.IMPL_MASK(IMPL_MASK)) u_dec (
        .set_we    (set_we),
        .set_wdata (set_wdata),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .req       (req)
    );

    for (genvar i = 0; i < PCE_IDS; i++) begin : g_cell
        pce_enable_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .on_req  (req.on_bits[i]),
            .off_req (req.off_bits[i]),
            .en      (en_q[i])
        );
    end

    assign clk_en = en_q;

endmodule

// File: rtl/pce_checker.sv
module pce_checker
    import pce_pkg::*;
#(
    parameter pce_vec_t IMPL_MASK = 32'h0FFF_FFFC
) (
    input logic        clk,
    input logic        rst,
    input logic        set_we,
    input logic [31:0] set_wdata,
    input logic        clr_we,
    input logic [31:0] clr_wdata,
    input logic [31:0] clk_en
);

    AST_RESET_OFF: assert property (@(posedge clk) rst |=> (clk_en == '0)); // R1

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=>
        ((clk_en & $past(set_wdata & IMPL_MASK)) == $past(set_wdata & IMPL_MASK))); // R2

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((clk_en & $past(clr_wdata)) == '0)); // R5

    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (set_we || clr_we) |=>
        (((clk_en ^ $past(clk_en)) &
          ~($past(set_we ? set_wdata : '0) | $past(clr_we ? clr_wdata : '0))) == '0)); // R4

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((clk_en & ~IMPL_MASK) == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(clk_en)); // R7

endmodule

bind periph_clk_enable pce_checker #(.IMPL_MASK(IMPL_MASK)) u_chk (.*);

// File: tb/sim_periph_clk_enable.sv
module sim_periph_clk_enable;

    localparam logic [31:0] MASK = 32'h0FFF_FFFC;

    logic        clk = 1'b0;
    logic        rst;
    logic        set_we;
    logic [31:0] set_wdata;
    logic        clr_we;
    logic [31:0] clr_wdata;
    logic [31:0] clk_en;

    logic [31:0] model;
    int          checks = 0;
    int          fails  = 0;
    int          cycles = 0;
    logic [31:0] lfsr;

    always #2.5 clk = ~clk;

    periph_clk_enable #(.IMPL_MASK(MASK)) u0 (
        .clk       (clk),
        .rst       (rst),
        .set_we    (set_we),
        .set_wdata (set_wdata),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .clk_en    (clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: clk_en=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check that nothing moves before
    // the rising edge, then check the result just after it.
    task automatic step(input string tag,
                        input logic sw, input logic [31:0] sd,
                        input logic cw, input logic [31:0] cd);
        @(negedge clk);
        set_we = sw; set_wdata = sd; clr_we = cw; clr_wdata = cd;
        #1;
        chk("R8", clk_en, model);
        model = (model | (sw ? sd : 32'h0)) & ~(cw ? cd : 32'h0) & MASK;
        @(posedge clk);
        #1;
        chk(tag, clk_en, model);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: clk_en=%h expected=finish", clk_en);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; set_we = 1'b0; clr_we = 1'b0;
        set_wdata = '1; clr_wdata = '0;
        model = '0;
        repeat (3) @(posedge clk);
        #1 chk("R1", clk_en, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1 chk("R1", clk_en, 32'h0);

        // R2/R6: walk a one through every set position.
        for (int i = 0; i < 32; i++)
            step(MASK[i] ? "R2" : "R6", 1'b1, 32'h1 << i, 1'b0, 32'h0);
        // R3: walk a one through every clear position.
        for (int i = 0; i < 32; i++)
            step("R3", 1'b0, 32'h0, 1'b1, 32'h1 << i);

        // R7: full data with strobes low.
        step("R7", 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0);
        step("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0);
        step("R7", 1'b0, 32'h0, 1'b0, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++)
            step("R8", 1'b0, 32'h0, 1'b0, 32'h0);

        // R4: zero bits keep their state.
        step("R4", 1'b0, 32'h0, 1'b1, 32'hA5A5_5A5A);
        step("R4", 1'b1, 32'h0000_0100, 1'b0, 32'h0);
        step("R4", 1'b1, 32'h0, 1'b1, 32'h0);

        // R5: collision on every position, with the bit first on.
        for (int i = 0; i < 32; i++) begin
            step("R2", 1'b1, 32'h1 << i, 1'b0, 32'h0);
            step("R5", 1'b1, 32'h1 << i, 1'b1, 32'h1 << i);
        end

        // Mixed pseudo-random traffic.
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            step("R4", a[3], a ^ b, b[5], b & {a[15:0], a[31:16]});
        end

        // R1: reset mid-run.
        step("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0);
        @(negedge clk);
        rst = 1'b1; set_we = 1'b1; set_wdata = '1;
        @(posedge clk);
        #1 chk("R1", clk_en, 32'h0);
        @(negedge clk);
        rst = 1'b0; set_we = 1'b0;
        model = '0;
        @(posedge clk);
        #1 chk("R1", clk_en, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule